// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block runs one fixed authentication transaction against a remote token on a single-wire bus. It does not generate bus waveforms itself. It drives a separate bit/byte bus master through a request/acknowledge command port, with three operations: bus reset with presence test, byte write, and byte read. The challenge (64 bits) and the expected response code (160 bits) are configuration inputs held by the surrounding logic.

A `start` pulse launches the transaction. The sequencer first resets the bus and sends the skip-addressing byte. It then sends the write-challenge command with the challenge bytes, and after that the compute command. Next it holds the strong pullup for a fixed interval, sends one all-zero byte (eight write-0 slots), and reads back 20 bytes, which it compares with the expected code as they arrive. A mismatch is retried up to the configured attempt count. A closing reset confirms that the token is still present before the result appears on two active-low status lines, driven as open-drain pull enables. The FAIL line can optionally blink instead of holding low. `abort` returns the block to idle at any time.

The states are IDLE, BUSRST, SKIPADR, CHALCMD, CHALDAT, MACCMD, PUWAIT, PULLUP, ZEROS, MACRD, JUDGE and CLOSE. The transitions are:

- IDLE→BUSRST on start.
- BUSRST→SKIPADR when presence is acknowledged, and BUSRST→IDLE when there is no presence.
- SKIPADR→CHALCMD→CHALDAT→MACCMD→PUWAIT→PULLUP→ZEROS→MACRD→JUDGE, in that order.
- JUDGE→BUSRST for a retry, or JUDGE→CLOSE.
- CLOSE→IDLE.
- Any state→IDLE on abort.

Top module: `auth_sequencer`

## Requirements
- R1: Each attempt begins with a reset op (bm_op=0), followed by write ops (bm_op=1) of CCh, 0Ch and then the 8 challenge bytes. The first challenge byte is cfg_challenge[7:0] and the last is cfg_challenge[63:56].
- R2: After the challenge, the attempt writes 36h. Once that write is acknowledged, bm_spu rises after exactly SPU_DLY cycles and stays high for exactly SPU_LEN cycles, with bm_req low throughout. A write of 00h follows.
- R3: Each attempt then issues 20 read ops (bm_op=2). Read k is compared with cfg_mac[8k+7:8k], and the attempt matches only if all 160 bits are equal.
- R4: cfg_tries of 0, 1, 2 and 3 allow 1, 2, 4 and 8 attempts respectively. A mismatching attempt is followed by a new attempt until that limit is reached.
- R5: Once an attempt matches, no further attempt is made.
- R6: After the last attempt, one closing reset op is issued. If presence is reported, pass_pull goes high on a match, and fail_pull goes high otherwise.
- R7: If any reset op reports no presence, the transaction ends with both pass_pull and fail_pull low (released).
- R8: pass_pull and fail_pull are never high together, and both are low while busy is high.
- R9: With cfg_fail_blink=1, a FAIL result drives fail_pull high for BLINK_HALF cycles and low for BLINK_HALF cycles, repeating, starting high. With cfg_fail_blink=0, fail_pull holds high.
- R10: abort returns the block to idle in the next cycle, with busy, bm_spu, pass_pull and fail_pull all low.
- R11: After reset, busy, bm_req, bm_spu, pass_pull and fail_pull are all low. busy is high from the cycle after start until the transaction ends, and a start during that time has no effect.
- R12: While bm_req is high and bm_ack is low, bm_req, bm_op and bm_wdata stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one transaction from idle |
| abort | input | 1 | Cancel the transaction and return to idle |
| cfg_challenge | input | 64 | Stored challenge, byte 0 in bits 7:0 |
| cfg_mac | input | 160 | Expected response, byte 0 in bits 7:0 |
| cfg_tries | input | 2 | Attempt-limit code (1, 2, 4 or 8 attempts) |
| cfg_fail_blink | input | 1 | Blink the FAIL output instead of holding it |
| bm_req | output | 1 | Operation request to the bus master |
| bm_op | output | 2 | 0 = reset/presence, 1 = write byte, 2 = read byte |
| bm_wdata | output | 8 | Byte to write |
| bm_spu | output | 1 | Strong pullup enable |
| bm_ack | input | 1 | One-cycle completion of the requested operation |
| bm_rdata | input | 8 | Byte read, valid with bm_ack |
| bm_presence | input | 1 | Presence seen during a reset, valid with bm_ack |
| busy | output | 1 | Transaction in progress |
| pass_pull | output | 1 | 1 = pull the PASS line low |
| fail_pull | output | 1 | 1 = pull the FAIL line low |

## Verification
A behavioural token answers the reads with the expected code, or with one byte corrupted on selected attempts. Corruption on every attempt distinguishes FAIL from PASS and shows that the attempt limit is enforced. Corruption only on early attempts shows that retrying stops at the first match. Withholding presence at the first reset, at a retry reset or at the closing reset separates the not-present outcome from FAIL. Random challenges, codes, attempt codes and corruption patterns are checked against the op log, and pulse stimuli on abort and start during pullup and mid-transaction test cancellation and that a second start is ignored.

// File: rtl/auth_pkg.sv
package auth_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BUSRST,
        ST_SKIPADR,
        ST_CHALCMD,
        ST_CHALDAT,
        ST_MACCMD,
        ST_PUWAIT,
        ST_PULLUP,
        ST_ZEROS,
        ST_MACRD,
        ST_JUDGE,
        ST_CLOSE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_PASS,
        RES_FAIL
    } verdict_e;

    localparam logic [7:0] BYTE_SKIPADR = 8'hCC;
    localparam logic [7:0] BYTE_CHALCMD = 8'h0C;
    localparam logic [7:0] BYTE_MACCMD  = 8'h36;
    localparam logic [7:0] BYTE_ZEROS   = 8'h00;

endpackage

// File: rtl/auth_step_counter.sv
module auth_step_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (inc) value <= value + W'(1);
    end
endmodule

// File: rtl/auth_mac_cmp.sv
module auth_mac_cmp #(
    parameter int BYTES = 20,
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         rx,
    input  logic [BYTES*8-1:0] expected,
    output logic               mismatch
);
    logic [7:0] want;
    assign want = expected[int'(idx)*8 +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mismatch <= 1'b0;
        else if (clr) mismatch <= 1'b0;
        else if (en)  mismatch <= mismatch | (rx != want);
    end
endmodule

// File: rtl/auth_status.sv
module auth_status
    import auth_pkg::*;
#(
    parameter int BLINK_HALF = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_e verdict,
    input  logic     blink_en,
    output logic     pass_pull,
    output logic     fail_pull
);
    localparam int CW = $clog2(BLINK_HALF) + 1;

    logic [CW-1:0] tick;
    logic          phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick  <= '0;
            phase <= 1'b1;
        end else if (verdict != RES_FAIL) begin
            tick  <= '0;
            phase <= 1'b1;
        end else if (tick == CW'(BLINK_HALF - 1)) begin
            tick  <= '0;
            phase <= ~phase;
        end else begin
            tick  <= tick + CW'(1);
        end
    end

    assign pass_pull = (verdict == RES_PASS);
    assign fail_pull = (verdict == RES_FAIL) && (!blink_en || phase);
endmodule

// File: rtl/auth_sequencer.sv
module auth_sequencer
    import auth_pkg::*;
#(
    parameter int CHAL_BYTES = 8,
    parameter int MAC_BYTES  = 20,
    parameter int SPU_DLY    = 4,
    parameter int SPU_LEN    = 40,
    parameter int BLINK_HALF = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    abort,
    input  logic [CHAL_BYTES*8-1:0] cfg_challenge,
    input  logic [MAC_BYTES*8-1:0]  cfg_mac,
    input  logic [1:0]              cfg_tries,
    input  logic                    cfg_fail_blink,
    output logic                    bm_req,
    output logic [1:0]              bm_op,
    output logic [7:0]              bm_wdata,
    output logic                    bm_spu,
    input  logic                    bm_ack,
    input  logic [7:0]              bm_rdata,
    input  logic                    bm_presence,
    output logic                    busy,
    output logic                    pass_pull,
    output logic                    fail_pull
);
    localparam int IDX_W   = $clog2(MAC_BYTES > CHAL_BYTES ? MAC_BYTES : CHAL_BYTES);
    localparam int TMAX    = SPU_DLY > SPU_LEN ? SPU_DLY : SPU_LEN;
    localparam int TMR_W   = $clog2(TMAX) + 1;

    seq_state_e state_q, state_d;
    verdict_e   verdict_q, verdict_d;
    logic [2:0] att_q, att_d, att_last;

    logic             idx_clr, idx_inc, tmr_clr, tmr_inc, cmp_clr, cmp_en;
    logic [IDX_W-1:0] idx;
    logic [TMR_W-1:0] tmr;
    logic             mismatch;

    auth_step_counter #(.W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc), .value(idx)
    );

    auth_step_counter #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .value(tmr)
    );

    auth_mac_cmp #(.BYTES(MAC_BYTES), .IDX_W(IDX_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .en(cmp_en), .idx(idx),
        .rx(bm_rdata), .expected(cfg_mac), .mismatch(mismatch)
    );

    auth_status #(.BLINK_HALF(BLINK_HALF)) u_status (
        .clk(clk), .rst_n(rst_n), .verdict(verdict_q), .blink_en(cfg_fail_blink),
        .pass_pull(pass_pull), .fail_pull(fail_pull)
    );

    always_comb begin
        unique case (cfg_tries)
            2'd0: att_last = 3'd0;
            2'd1: att_last = 3'd1;
            2'd2: att_last = 3'd3;
            default: att_last = 3'd7;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= RES_NONE;
            att_q     <= '0;
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
            att_q     <= att_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d   = state_q;
        verdict_d = verdict_q;
        att_d     = att_q;
        idx_clr   = 1'b0;
        idx_inc   = 1'b0;
        tmr_clr   = 1'b0;
        tmr_inc   = 1'b0;
        cmp_clr   = 1'b0;
        cmp_en    = 1'b0;
        if (abort) begin
            state_d   = ST_IDLE;
            verdict_d = RES_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_d   = ST_BUSRST;
                    verdict_d = RES_NONE;
                    att_d     = '0;
                end
                ST_BUSRST: if (bm_ack) begin
                    state_d = bm_presence ? ST_SKIPADR : ST_IDLE;
                end
                ST_SKIPADR: if (bm_ack) state_d = ST_CHALCMD;
                ST_CHALCMD: if (bm_ack) begin
                    state_d = ST_CHALDAT;
                    idx_clr = 1'b1;
                end
                ST_CHALDAT: if (bm_ack) begin
                    if (idx == IDX_W'(CHAL_BYTES - 1)) begin
                        state_d = ST_MACCMD;
                        idx_clr = 1'b1;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
                ST_MACCMD: if (bm_ack) begin
                    state_d = ST_PUWAIT;
                    tmr_clr = 1'b1;
                end
                ST_PUWAIT: begin
                    if (tmr == TMR_W'(SPU_DLY - 1)) begin
                        state_d = ST_PULLUP;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
                ST_PULLUP: begin
                    if (tmr == TMR_W'(SPU_LEN - 1)) begin
                        state_d = ST_ZEROS;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
                ST_ZEROS: if (bm_ack) begin
                    state_d = ST_MACRD;
                    idx_clr = 1'b1;
                    cmp_clr = 1'b1;
                end
                ST_MACRD: if (bm_ack) begin
                    cmp_en = 1'b1;
                    if (idx == IDX_W'(MAC_BYTES - 1)) begin
                        state_d = ST_JUDGE;
                        idx_clr = 1'b1;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
                ST_JUDGE: begin
                    if (!mismatch || att_q == att_last) begin
                        state_d = ST_CLOSE;
                    end else begin
                        att_d   = att_q + 3'd1;
                        state_d = ST_BUSRST;
                    end
                end
                ST_CLOSE: if (bm_ack) begin
                    state_d = ST_IDLE;
                    if (!bm_presence) verdict_d = RES_NONE;
                    else if (mismatch) verdict_d = RES_FAIL;
                    else verdict_d = RES_PASS;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bm_req   = 1'b0;
        bm_op    = OP_WRITE;
        bm_wdata = BYTE_ZEROS;
        bm_spu   = 1'b0;
        busy     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_BUSRST, ST_CLOSE: begin
                bm_req = 1'b1;
                bm_op  = OP_RESET;
            end
            ST_SKIPADR: begin
                bm_req   = 1'b1;
                bm_wdata = BYTE_SKIPADR;
            end
            ST_CHALCMD: begin
                bm_req   = 1'b1;
                bm_wdata = BYTE_CHALCMD;
            end
            ST_CHALDAT: begin
                bm_req   = 1'b1;
                bm_wdata = cfg_challenge[int'(idx)*8 +: 8];
            end
            ST_MACCMD: begin
                bm_req   = 1'b1;
                bm_wdata = BYTE_MACCMD;
            end
            ST_ZEROS: begin
                bm_req   = 1'b1;
                bm_wdata = BYTE_ZEROS;
            end
            ST_MACRD: begin
                bm_req = 1'b1;
                bm_op  = OP_READ;
            end
            ST_PULLUP: bm_spu = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/auth_sequencer_chk.sv
module auth_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       abort,
    input logic       bm_req,
    input logic [1:0] bm_op,
    input logic [7:0] bm_wdata,
    input logic       bm_spu,
    input logic       bm_ack,
    input logic       bm_presence,
    input logic       busy,
    input logic       pass_pull,
    input logic       fail_pull
);
    AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_pull && fail_pull)); // R8
    AST_RELEASED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!pass_pull && !fail_pull)); // R8
    AST_NO_REQ_IN_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        bm_spu |-> !bm_req); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && !bm_ack && !abort) |=> (bm_req && $stable(bm_op) && $stable(bm_wdata))); // R12
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !bm_spu && !pass_pull && !fail_pull)); // R10
    AST_ABSENT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && bm_op == 2'd0 && bm_ack && !bm_presence && !abort)
            |=> (!busy && !pass_pull && !fail_pull)); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && !busy) |=> busy); // R11
endmodule

bind auth_sequencer auth_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .bm_req(bm_req), .bm_op(bm_op), .bm_wdata(bm_wdata), .bm_spu(bm_spu),
    .bm_ack(bm_ack), .bm_presence(bm_presence), .busy(busy),
    .pass_pull(pass_pull), .fail_pull(fail_pull)
);

// File: tb/sim_auth_sequencer.sv
`timescale 1ns/1ps
module sim_auth_sequencer;
    localparam int SPU_DLY    = 4;
    localparam int SPU_LEN    = 40;
    localparam int BLINK_HALF = 16;
    localparam int LAT        = 3;
    localparam int OPS_ATT    = 33;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         abort = 1'b0;
    logic [63:0]  cfg_challenge = '0;
    logic [159:0] cfg_mac = '0;
    logic [1:0]   cfg_tries = '0;
    logic         cfg_fail_blink = 1'b0;
    logic         bm_req;
    logic [1:0]   bm_op;
    logic [7:0]   bm_wdata;
    logic         bm_spu;
    logic         bm_ack = 1'b0;
    logic [7:0]   bm_rdata = '0;
    logic         bm_presence = 1'b0;
    logic         busy, pass_pull, fail_pull;

    always #2.5 clk = ~clk;

    auth_sequencer #(.SPU_DLY(SPU_DLY), .SPU_LEN(SPU_LEN), .BLINK_HALF(BLINK_HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .cfg_challenge(cfg_challenge), .cfg_mac(cfg_mac), .cfg_tries(cfg_tries),
        .cfg_fail_blink(cfg_fail_blink), .bm_req(bm_req), .bm_op(bm_op),
        .bm_wdata(bm_wdata), .bm_spu(bm_spu), .bm_ack(bm_ack), .bm_rdata(bm_rdata),
        .bm_presence(bm_presence), .busy(busy), .pass_pull(pass_pull), .fail_pull(fail_pull)
    );

    int errors = 0;
    int checks = 0;

    // token scenario
    logic [7:0] t_corrupt = '0;
    int         t_pres_fail = -1;
    int         t_bad_byte = 0;

    // bus model state and log
    int         m_cnt = 0;
    logic [1:0] m_op = '0;
    int         rst_seen = 0;
    int         rd_idx = 0;
    int         n_ops = 0;
    logic [9:0] op_log [0:299];
    int         spu_hi = 0;
    int         spu_dly_meas = -1;
    int         dly_run = -1;
    int         spu_req_viol = 0;
    int         hold_viol = 0;
    logic       p_req = 1'b0, p_ack = 1'b0;
    logic [1:0] p_op = '0;
    logic [7:0] p_wd = '0;

    always @(posedge clk) begin
        bm_ack <= 1'b0;
        if (m_cnt == 0) begin
            if (bm_req && !bm_ack) begin
                m_op = bm_op;
                if (n_ops < 300) op_log[n_ops] = {bm_op, bm_wdata};
                n_ops = n_ops + 1;
                m_cnt = LAT;
            end
        end else if (m_cnt == 1) begin
            m_cnt = 0;
            bm_ack <= 1'b1;
            if (m_op == 2'd0) begin
                bm_presence <= (rst_seen != t_pres_fail);
                rst_seen = rst_seen + 1;
                rd_idx = 0;
            end else if (m_op == 2'd2) begin
                bm_rdata <= cfg_mac[rd_idx*8 +: 8] ^
                            ((t_corrupt[(rst_seen-1) & 7] && rd_idx == t_bad_byte) ? 8'h5A : 8'h00);
                rd_idx = rd_idx + 1;
            end
        end else begin
            m_cnt = m_cnt - 1;
        end
    end

    // observers at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bm_spu) spu_hi = spu_hi + 1;
            if (bm_spu && bm_req) spu_req_viol = spu_req_viol + 1;
            if (p_req && !p_ack && !abort && !(bm_req && bm_op == p_op && bm_wdata == p_wd))
                hold_viol = hold_viol + 1;
            if (dly_run >= 0) begin
                if (bm_spu) begin
                    if (spu_dly_meas < 0) spu_dly_meas = dly_run;
                    dly_run = -1;
                end else dly_run = dly_run + 1;
            end
            if (bm_req && bm_ack && bm_op == 2'd1 && bm_wdata == 8'h36) dly_run = 0;
            p_req = bm_req; p_ack = bm_ack; p_op = bm_op; p_wd = bm_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_entry(input int k);
        if (k == 0) return {2'd0, 8'h00};
        if (k == 1) return {2'd1, 8'hCC};
        if (k == 2) return {2'd1, 8'h0C};
        if (k < 11) return {2'd1, cfg_challenge[(k-3)*8 +: 8]};
        if (k == 11) return {2'd1, 8'h36};
        if (k == 12) return {2'd1, 8'h00};
        return {2'd2, 8'h00};
    endfunction

    // expected outcome: 0 none, 1 pass, 2 fail; number of ops; full attempts
    task automatic predict(output int res, output int ops, output int full);
        int limit;
        bit good;
        limit = 1 << cfg_tries;
        good = 0;
        full = 0;
        res = -1;
        for (int a = 0; a < limit; a++) begin
            if (a == t_pres_fail) begin res = 0; ops = a * OPS_ATT + 1; return; end
            full++;
            if (!t_corrupt[a]) begin good = 1; break; end
        end
        ops = full * OPS_ATT + 1;
        if (full == t_pres_fail) res = 0;
        else res = good ? 1 : 2;
    endtask

    task automatic clear_log();
        n_ops = 0; rst_seen = 0; rd_idx = 0; spu_hi = 0;
        spu_dly_meas = -1; dly_run = -1; spu_req_viol = 0; hold_viol = 0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        if (busy) chk(1'b0, "R11 watchdog", 1, 0);
    endtask

    task automatic run_auth(input bit extra_start, input string tag);
        int eres, eops, efull, bad;
        clear_log();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, {tag, " R11 busy after start"}, busy, 1);
        if (extra_start) begin
            repeat (50) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_idle();
        predict(eres, eops, efull);
        chk(n_ops == eops, {tag, " R4 R5 R7 op count"}, n_ops, eops);
        bad = 0;
        for (int i = 0; i < n_ops && i < 300; i++) begin
            if (i == eops - 1 && eres != 0 || i == efull * OPS_ATT) begin
                if (op_log[i][9:8] != 2'd0) bad++;
            end else if (op_log[i] != exp_entry(i % OPS_ATT)) bad++;
        end
        chk(bad == 0, {tag, " R1 R3 R6 op log"}, bad, 0);
        chk(spu_hi == efull * SPU_LEN, {tag, " R2 pullup length"}, spu_hi, efull * SPU_LEN);
        if (efull > 0)
            chk(spu_dly_meas == SPU_DLY, {tag, " R2 pullup delay"}, spu_dly_meas, SPU_DLY);
        chk(spu_req_viol == 0, {tag, " R2 no request in pullup"}, spu_req_viol, 0);
        chk(hold_viol == 0, {tag, " R12 request held"}, hold_viol, 0);
        chk(pass_pull == (eres == 1), {tag, " R6 pass_pull"}, pass_pull, eres == 1);
        chk(fail_pull == (eres == 2), {tag, " R6 R7 fail_pull"}, fail_pull, eres == 2);
    endtask

    task automatic set_scn(input logic [1:0] tries, input logic [7:0] corr, input int pf);
        cfg_tries = tries; t_corrupt = corr; t_pres_fail = pf;
    endtask

    initial begin
        int cnt;
        bit  seen_low;
        void'($urandom(32'd20240611));
        cfg_challenge = 64'h0123_4567_89AB_CDEF;
        cfg_mac = {32'hDEADBEEF, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_F00D};
        repeat (3) @(negedge clk);
        chk(!busy && !bm_req && !bm_spu && !pass_pull && !fail_pull, "R11 reset state",
            {busy, bm_req, bm_spu, pass_pull, fail_pull}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        t_bad_byte = 19;
        set_scn(2'd0, 8'h00, -1); run_auth(0, "single pass");
        set_scn(2'd2, 8'hFF, -1); run_auth(0, "R4 four fails");
        cnt = 0;
        for (int i = 0; i < 4 * BLINK_HALF; i++) begin @(negedge clk); cnt += fail_pull; end
        chk(cnt == 4 * BLINK_HALF, "R9 steady fail", cnt, 4 * BLINK_HALF);

        t_bad_byte = 0;
        set_scn(2'd3, 8'h07, -1); run_auth(0, "R5 pass on fourth");
        set_scn(2'd1, 8'h00, 0);  run_auth(0, "R7 absent first");
        set_scn(2'd0, 8'h00, 1);  run_auth(0, "R7 absent closing");
        set_scn(2'd1, 8'h01, 1);  run_auth(0, "R7 absent retry");
        set_scn(2'd0, 8'h00, -1); run_auth(1, "R11 second start");

        cfg_fail_blink = 1'b1;
        set_scn(2'd0, 8'h01, -1); run_auth(0, "R9 blink fail");
        cnt = 0; seen_low = 0;
        for (int i = 0; i < 4 * BLINK_HALF; i++) begin
            @(negedge clk); cnt += fail_pull; if (!fail_pull) seen_low = 1;
        end
        chk(cnt == 2 * BLINK_HALF, "R9 blink duty", cnt, 2 * BLINK_HALF);
        chk(seen_low && !pass_pull, "R9 blink toggles", seen_low, 1);
        cfg_fail_blink = 1'b0;

        // abort during pullup
        set_scn(2'd0, 8'h00, -1); clear_log();
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        cnt = 0;
        while (!bm_spu && cnt < 2000) begin @(negedge clk); cnt++; end
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk(!busy && !bm_spu && !pass_pull && !fail_pull, "R10 abort",
            {busy, bm_spu, pass_pull, fail_pull}, 0);
        repeat (20) @(negedge clk);
        chk(!busy && !bm_req, "R10 stays idle", {busy, bm_req}, 0);

        for (int r = 0; r < 25; r++) begin
            cfg_challenge = {$urandom, $urandom};
            cfg_mac = {$urandom, $urandom, $urandom, $urandom, $urandom};
            t_bad_byte = $urandom_range(19, 0);
            cfg_fail_blink = 1'b0;
            set_scn(2'($urandom_range(3, 0)), 8'($urandom),
                    ($urandom_range(7, 0) == 0) ? int'($urandom_range(3, 0)) : -1);
            run_auth(0, "random");
            repeat (5) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL R11 global watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule